// File: doc/BRIEF.md
# Precision-Reconfigurable Matrix Multiply Array

This block multiplies two small square matrices of unsigned integers on a fixed grid of 4x4-bit multipliers. The grid is sized by a datapath width of 16 bits, which gives 16 nibble multipliers. A precision code chosen with the start beat sets the item width to 4, 8 or 16 bits. The matrix size then follows as h = 16 / item width, so the block handles 4x4, 2x2 or 1x1 matrices.

The user streams one beat per matrix pair for each inner index k. A beat carries column k of the left matrix and row k of the right matrix. The nibble grid always forms every nibble-by-nibble product of the two 16-bit buses. The precision code only controls how these products are grouped, shifted and summed into item products. Chains of three-input adders reduce the partial products. A bank of accumulators then sums the h outer products. The finished result matrix is shown with a one-cycle valid strobe. Larger matrices are cut into tiles outside the block.

Top module: `mmr_prec_matmul`

## Requirements
- R1: The precision code `prec` is sampled only with the start beat. Code 0 selects 4-bit items with h = 4, code 1 selects 8-bit items with h = 2, and codes 2 and 3 both select 16-bit items with h = 1.
- R2: Within a beat, item i of the left column sits at `x_col[i*b +: b]`, and item j of the right row sits at `y_row[j*b +: b]`, where b is the item width.
- R3: Element (i, j) of the product, equal to the sum over k of X[i][k]*Y[k][j] taken unsigned, appears zero-extended to 32 bits at `result[(i*h+j)*32 +: 32]`. Every slot with an index of h*h or more reads zero.
- R4: Let L be the clock edge that samples the last beat of a matrix. Then `out_valid` is high for exactly the one cycle between edges L+1 and L+2, and that cycle carries the final result.
- R5: The start beat is the first of h beats. A later beat is any cycle with `in_valid` high while a matrix is in progress. Cycles with `in_valid` low between beats add nothing and do not change the result.
- R6: While a matrix is in progress, `start` and `prec` have no effect.
- R7: While no matrix is in progress, `in_valid` without `start` is ignored. It produces no `out_valid` pulse and leaves `result` unchanged.
- R8: A new start beat is accepted on the cycle right after the previous matrix's last beat. The accumulators restart from the new products, with nothing carried over from the previous matrix.
- R9: During reset, `out_valid` is low and every `result` slot is zero.
- R10: Once a result is presented, `result` holds its value until the next matrix's products start to accumulate.
- R11: No overflow occurs at any precision. Operands that are all ones give (2^b-1)^2 * h in every used slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks the first beat of a matrix pair when idle |
| prec | input | 2 | Precision code, sampled with the start beat |
| in_valid | input | 1 | Beat qualifier |
| x_col | input | 16 | Column k of the left matrix, h packed items |
| y_row | input | 16 | Row k of the right matrix, h packed items |
| out_valid | output | 1 | One-cycle strobe marking the finished result |
| result | output | 512 | 16 slots of 32 bits, row-major result elements |

## Verification
The bench compares every slot of every result against a triple-loop reference. It does this at each precision, for code 3, and for all-ones operands, where a dropped carry or a wrong nibble shift would show up as a truncated or misplaced sum. It streams beats with idle gaps, and it toggles `start` and `prec` in the middle of a matrix. A design that counts idle cycles as beats, or that re-samples the precision, would strobe early or mix groupings. Matrices are also sent back to back with no idle cycle between them, so a design that fails to clear its accumulators on the new start beat would add in the previous sum. Stray `in_valid` pulses while idle are checked for a spurious strobe and for any change to the held result.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

  // width of one leaf multiplier operand
  localparam int unsigned NIB_W = 4;

  // control that travels with a beat into the accumulate stage
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } beat_tag_t;

  // leaf product of two nibbles
  function automatic logic [2*NIB_W-1:0] nib_mul(input logic [NIB_W-1:0] a,
                                                 input logic [NIB_W-1:0] b);
    return (2*NIB_W)'(a) * (2*NIB_W)'(b);
  endfunction

endpackage

// File: rtl/mmr_nib_array.sv
module mmr_nib_array #(
  parameter int unsigned DW = 16,
  localparam int unsigned NW = mmr_pkg::NIB_W,
  localparam int unsigned NN = DW / NW,
  localparam int unsigned PPW = 2 * NW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [DW-1:0]         a_in,
  input  logic [DW-1:0]         b_in,
  output logic [NN*NN*PPW-1:0]  pp_flat
);

  // every nibble of a_in times every nibble of b_in, registered
  for (genvar p = 0; p < NN; p++) begin : g_row
    for (genvar q = 0; q < NN; q++) begin : g_col
      logic [PPW-1:0] pp_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pp_r <= '0;
        else if (en) pp_r <= mmr_pkg::nib_mul(a_in[p*NW +: NW], b_in[q*NW +: NW]);
      end
      assign pp_flat[(p*NN+q)*PPW +: PPW] = pp_r;
    end
  end

endmodule

// File: rtl/mmr_reduce.sv
module mmr_reduce #(
  parameter int unsigned DW = 16,
  localparam int unsigned NW = mmr_pkg::NIB_W,
  localparam int unsigned NN = DW / NW,
  localparam int unsigned NPP = NN * NN,
  localparam int unsigned PPW = 2 * NW,
  localparam int unsigned LV = $clog2(NN),
  localparam int unsigned SHW = (LV > 0) ? $clog2(LV + 1) : 1,
  localparam int unsigned RW = 2 * DW
) (
  input  logic [SHW-1:0]      sh,
  input  logic [NPP*PPW-1:0]  pp_flat,
  output logic [NPP*RW-1:0]   prod_flat
);

  function automatic logic [RW-1:0] add3(input logic [RW-1:0] a,
                                         input logic [RW-1:0] b,
                                         input logic [RW-1:0] c);
    return a + b + c;
  endfunction

  // one nibble product routed to element (i,j), weighted by its place
  function automatic logic [RW-1:0] term_of(input int unsigned t, input int unsigned s,
                                            input int unsigned i, input int unsigned j,
                                            input logic [NPP*PPW-1:0] pps);
    int unsigned p, q, msk, wsh;
    p   = t / NN;
    q   = t % NN;
    msk = (1 << s) - 1;
    wsh = NW * ((p & msk) + (q & msk));
    if (((p >> s) == i) && ((q >> s) == j))
      return RW'(pps[t*PPW +: PPW]) << wsh;
    return '0;
  endfunction

  // item product for slot e under grouping shift s (b = NW << s)
  function automatic logic [RW-1:0] elem_product(input int unsigned e, input int unsigned s,
                                                 input logic [NPP*PPW-1:0] pps);
    int unsigned hsh, i, j;
    logic [RW-1:0] acc;
    hsh = LV - s;
    i   = e >> hsh;
    j   = e & ((1 << hsh) - 1);
    acc = '0;
    for (int unsigned k = 0; k < NPP; k += 2)
      acc = add3(acc, term_of(k, s, i, j, pps), term_of(k + 1, s, i, j, pps));
    return acc;
  endfunction

  for (genvar e = 0; e < NPP; e++) begin : g_elem
    assign prod_flat[e*RW +: RW] = elem_product(e, int'(sh), pp_flat);
  end

endmodule

// File: rtl/mmr_acc_bank.sv
module mmr_acc_bank #(
  parameter int unsigned NE = 16,
  parameter int unsigned RW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [NE*RW-1:0]  prod_flat,
  output logic [NE*RW-1:0]  acc_flat
);

  for (genvar e = 0; e < NE; e++) begin : g_acc
    logic [RW-1:0] acc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_r <= '0;
      else if (en) begin
        if (load)       acc_r <= prod_flat[e*RW +: RW];
        else            acc_r <= acc_r + prod_flat[e*RW +: RW];
      end
    end
    assign acc_flat[e*RW +: RW] = acc_r;
  end

endmodule

// File: rtl/mmr_prec_matmul.sv
module mmr_prec_matmul #(
  parameter int unsigned DW = 16,
  localparam int unsigned NW = mmr_pkg::NIB_W,
  localparam int unsigned NN = DW / NW,
  localparam int unsigned NPP = NN * NN,
  localparam int unsigned PPW = 2 * NW,
  localparam int unsigned LV = $clog2(NN),
  localparam int unsigned SHW = (LV > 0) ? $clog2(LV + 1) : 1,
  localparam int unsigned CW = LV + 1,
  localparam int unsigned RW = 2 * DW,
  localparam int unsigned RES_W = NPP * RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        prec,
  input  logic              in_valid,
  input  logic [DW-1:0]     x_col,
  input  logic [DW-1:0]     y_row,
  output logic              out_valid,
  output logic [RES_W-1:0]  result
);

  // precision code to grouping shift, codes past the widest fold onto it
  function automatic logic [SHW-1:0] sh_of(input logic [1:0] code);
    if (int'(code) > int'(LV)) return SHW'(LV);
    return SHW'(code);
  endfunction

  logic                busy_q;
  logic [SHW-1:0]      sh_q, sh_s1, sh_new, sh_cur;
  logic [CW-1:0]       cnt_q, cnt_beat, h_cur;
  mmr_pkg::beat_tag_t  tag_q;
  logic                out_valid_q;

  // named events
  logic                take_start, beat_acc, last_beat, s1_vld;
  logic [NPP*PPW-1:0]  pp_flat;
  logic [NPP*RW-1:0]   prod_flat;

  always_comb begin
    sh_new     = sh_of(prec);
    take_start = rst_n && start && in_valid && !busy_q;
    beat_acc   = take_start || (rst_n && in_valid && busy_q);
    sh_cur     = busy_q ? sh_q : sh_new;
    h_cur      = CW'(NN >> sh_cur);
    cnt_beat   = busy_q ? cnt_q : '0;
    last_beat  = beat_acc && (cnt_beat == h_cur - CW'(1));
  end

  assign s1_vld = tag_q.vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      sh_q        <= '0;
      cnt_q       <= '0;
      sh_s1       <= '0;
      tag_q       <= '0;
      out_valid_q <= 1'b0;
    end else begin
      if (take_start) sh_q <= sh_new;
      if (beat_acc) begin
        sh_s1 <= sh_cur;
        if (last_beat) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= cnt_beat + CW'(1);
        end
      end
      tag_q.vld   <= beat_acc;
      tag_q.first <= take_start;
      tag_q.last  <= last_beat;
      out_valid_q <= tag_q.vld && tag_q.last;
    end
  end

  mmr_nib_array #(.DW(DW)) u_grid (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (beat_acc),
    .a_in    (x_col),
    .b_in    (y_row),
    .pp_flat (pp_flat)
  );

  mmr_reduce #(.DW(DW)) u_reduce (
    .sh        (sh_s1),
    .pp_flat   (pp_flat),
    .prod_flat (prod_flat)
  );

  mmr_acc_bank #(.NE(NPP), .RW(RW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (s1_vld),
    .load      (tag_q.first),
    .prod_flat (prod_flat),
    .acc_flat  (result)
  );

  assign out_valid = out_valid_q;

endmodule

// File: rtl/mmr_prec_matmul_chk.sv
module mmr_prec_matmul_chk #(
  parameter int unsigned SHW = 2,
  parameter int unsigned RES_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             take_start,
  input logic             last_beat,
  input logic             s1_vld,
  input logic             out_valid,
  input logic [SHW-1:0]   sh_q,
  input logic [RES_W-1:0] result
);

  // strobe exactly two edges after the last beat is sampled
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(last_beat, 2));

  // precision frozen while a matrix is in flight
  p_prec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sh_q));

  // idle stays idle without an accepted start beat
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take_start) |=> !busy);

  // result only moves when products reach the accumulators
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(result));

endmodule

bind mmr_prec_matmul mmr_prec_matmul_chk #(.SHW(SHW), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_q),
  .take_start (take_start),
  .last_beat  (last_beat),
  .s1_vld     (s1_vld),
  .out_valid  (out_valid),
  .sh_q       (sh_q),
  .result     (result)
);

// File: tb/tb_mmr_prec_matmul.sv
module tb_mmr_prec_matmul;
  localparam int DW = 16;
  localparam int NN = 4;
  localparam int NPP = 16;
  localparam int RW = 32;
  typedef logic [NPP*RW-1:0] res_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [1:0] prec = 2'd0;
  logic [DW-1:0] x_col = '0, y_row = '0;
  logic out_valid;
  res_t result;

  always #5 clk = ~clk;

  mmr_prec_matmul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prec(prec), .in_valid(in_valid),
    .x_col(x_col), .y_row(y_row), .out_valid(out_valid), .result(result)
  );

  res_t  exp_q[$];
  int    cyc_q[$];
  string lbl_q[$];
  int    n_cmp = 0, n_bad = 0, cyc = 0;
  int unsigned seed = 32'h1234_5678;
  res_t  last_res = '0;
  logic [DW-1:0] mx [NN][NN];
  logic [DW-1:0] my [NN][NN];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RW-1:0] act, input logic [RW-1:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int bits_of(input int code);
    return 4 << ((code > 2) ? 2 : code);
  endfunction

  task automatic fill(input int code, input int kind);
    int b, msk;
    b = bits_of(code);
    msk = (1 << b) - 1;
    for (int i = 0; i < NN; i++)
      for (int k = 0; k < NN; k++) begin
        case (kind)
          0: begin mx[i][k] = DW'(rnd() & msk); my[i][k] = DW'(rnd() & msk); end
          1: begin mx[i][k] = DW'(msk); my[i][k] = DW'(msk); end
          default: begin mx[i][k] = (i == k) ? DW'(1) : DW'(0); my[i][k] = DW'(rnd() & msk); end
        endcase
      end
  endtask

  // driver: pushes the reference, then streams h beats (called at a negedge)
  task automatic run_mat(input int code, input int gap, input bit noise, input string lbl);
    int b, h;
    res_t e;
    logic [RW-1:0] acc;
    logic [DW-1:0] xv, yv;
    b = bits_of(code);
    h = DW / b;
    e = '0;
    for (int i = 0; i < h; i++)
      for (int j = 0; j < h; j++) begin
        acc = '0;
        for (int k = 0; k < h; k++) acc += RW'(mx[i][k]) * RW'(my[k][j]);
        e[(i*h+j)*RW +: RW] = acc;
      end
    exp_q.push_back(e);
    cyc_q.push_back(cyc + 2 + (h - 1) * (gap + 1));
    lbl_q.push_back(lbl);
    for (int k = 0; k < h; k++) begin
      xv = '0; yv = '0;
      for (int i = 0; i < h; i++) begin
        xv |= mx[i][k] << (i * b);
        yv |= my[k][i] << (i * b);
      end
      in_valid = 1'b1; x_col = xv; y_row = yv;
      start = (k == 0) ? 1'b1 : noise;
      prec = (k == 0 || !noise) ? 2'(code) : (2'(code) ^ 2'b11);
      @(negedge clk);
      if (k < h - 1)
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0; start = noise; x_col = ~xv;
          prec = noise ? (2'(code) ^ 2'b01) : 2'(code);
          @(negedge clk);
        end
    end
    in_valid = 1'b0; start = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever the strobe is seen
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "strobe with nothing pending", 32'd1, 32'd0);
      end else begin
        res_t  e;
        int    c;
        string l;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        l = lbl_q.pop_front();
        check(cyc == c, "R4", {l, " strobe cycle"}, RW'(cyc), RW'(c));
        for (int s = 0; s < NPP; s++)
          check(result[s*RW +: RW] == e[s*RW +: RW], {l, "/R3"}, $sformatf("slot %0d", s),
                result[s*RW +: RW], e[s*RW +: RW]);
        last_res = result;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", RW'(out_valid), 32'd0);
    for (int s = 0; s < NPP; s++)
      check(result[s*RW +: RW] == '0, "R9", "slot in reset", result[s*RW +: RW], 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R2: each precision code with random items
    for (int code = 0; code < 4; code++) begin
      fill(code, 0); run_mat(code, 0, 1'b0, "R1");
      repeat (3) @(negedge clk);
    end
    fill(0, 2); run_mat(0, 0, 1'b0, "R2");
    repeat (3) @(negedge clk);

    // R11: all-ones operands at every width
    for (int code = 0; code < 3; code++) begin
      fill(code, 1); run_mat(code, 0, 1'b0, "R11");
      repeat (3) @(negedge clk);
    end

    // R5, R6: gaps between beats, start and prec toggled mid-matrix
    fill(0, 0); run_mat(0, 2, 1'b1, "R6");
    repeat (3) @(negedge clk);
    fill(1, 0); run_mat(1, 1, 1'b1, "R5");
    repeat (3) @(negedge clk);

    // R8: back-to-back matrices, including single-beat ones
    fill(0, 0); run_mat(0, 0, 1'b0, "R8");
    fill(1, 1); run_mat(1, 0, 1'b0, "R8");
    fill(2, 0); run_mat(2, 0, 1'b0, "R8");
    fill(3, 0); run_mat(3, 0, 1'b0, "R8");
    fill(0, 0); run_mat(0, 0, 1'b0, "R8");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    // R7, R10: stray beats while idle; result must hold
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; start = 1'b0; prec = 2'd1;
      x_col = DW'(rnd()); y_row = DW'(rnd());
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    for (int s = 0; s < NPP; s++)
      check(result[s*RW +: RW] == last_res[s*RW +: RW], "R7", "slot after stray beats",
            result[s*RW +: RW], last_res[s*RW +: RW]);
    check(result == last_res, "R10", "held result", result[RW-1:0], last_res[RW-1:0]);

    check(exp_q.size() == 0, "R4", "results still pending", RW'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule